// File: doc/BRIEF.md
# Open-Wire Diagnostic Comparison Sequencer

This block runs the digital half of an open-wire test on a sixteen-channel cell-voltage monitor and on its multiplexed auxiliary input. While a current sink or source pulls on each sense pin, a broken wire makes the affected reading drift out of range. The host programs a comparison-select code, a 4-bit threshold code and the sink-control field through a small byte-wide register write port. It then sets a self-clearing go bit.

Once started, the block takes the next conversion result of each channel it must test. For the cell-voltage check it reads the main-ADC result stream and tests every enabled channel. For the auxiliary check it reads the aux-ADC result stream and tests the first aux result. Each result is compared against the expanded threshold, code × THR_STEP + THR_BASE. A reading below that value sets the channel's fault bit, and a reading at or above it clears the bit. When the pass is complete, a data-ready flag is raised for that check. If the go bit arrives while the matching ADC is not converting continuously, the block runs nothing and raises a sticky start error.

Top module: `ow_diag_seq`

## Requirements
- R1: After reset, busy, both data-ready flags, the start error, all fault bits, the aux diagnostic value, the select code, the threshold code and the sink code are all zero.
- R2: A write to address 0 stores select = data[2:0] and sink code = data[5:4], both visible at the ports from the next cycle. Bit 3 (go) is never held. A write to address 1 stores threshold code = data[3:0].
- R3: Go written with select 3'b010 while main_cont is high and the block is idle starts the cell-voltage check. During that check, the first main result of each channel enabled at start sets that channel's fault bit when data < code*THR_STEP+THR_BASE and clears the bit otherwise. Results from disabled or already-tested channels are ignored.
- R4: Busy falls and vs_drdy sets on the clock edge that takes the last outstanding channel. With no channel enabled, this happens one cycle after the start. Each start clears its own data-ready flag.
- R5: vs_fault shows 0 for every channel whose vs_chan_en bit is low. A check overwrites only the channels it tests, and all other fault bits keep their value.
- R6: Go with select 3'b011 while aux_cont is high starts the aux check. The first aux result after the start writes the fault bit numbered by aux_chan, using the same threshold rule. On that edge busy falls and aux_drdy sets.
- R7: When aux_locked is high, the aux result used by the check is copied into aux_diag. With aux_locked low, or during a cell-voltage check, aux_diag is left unchanged.
- R8: Go with an open-wire select code while the matching ADC is not continuous (main_cont for 3'b010, aux_cont for 3'b011) starts nothing, leaves all fault bits unchanged, and sets start_err until it is cleared.
- R9: Writing 1s clears status and fault bits, and 0 bits have no effect. Address 2 clears bit0 vs_drdy, bit1 aux_drdy and bit2 start_err. Addresses 3 and 4 clear VS fault bits 7:0 and 15:8. Addresses 5 and 6 clear aux fault bits 7:0 and 15:8.
- R10: Go is ignored when select is not 3'b010 or 3'b011, and it is ignored while a check is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 8 | Register write data |
| vs_chan_en | input | 16 | Active cell-voltage channels |
| main_cont | input | 1 | Main ADC is converting continuously |
| aux_cont | input | 1 | Aux ADC is converting continuously |
| aux_locked | input | 1 | Aux multiplexer is held on one channel |
| main_valid | input | 1 | Main-ADC result strobe |
| main_chan | input | 4 | Channel of the main result |
| main_data | input | DW | Main result value |
| aux_valid | input | 1 | Aux-ADC result strobe |
| aux_chan | input | 4 | Channel of the aux result |
| aux_data | input | DW | Aux result value |
| sink_ctrl | output | 2 | Current sink/source enable code |
| cmp_sel | output | 3 | Stored comparison-select code |
| thr_code | output | 4 | Stored threshold code |
| busy | output | 1 | A check is running |
| vs_drdy | output | 1 | Cell-voltage check complete |
| aux_drdy | output | 1 | Aux check complete |
| start_err | output | 1 | Sticky invalid-start flag |
| vs_fault | output | 16 | Cell-voltage open-wire flags, masked by vs_chan_en |
| aux_fault | output | 16 | Aux open-wire flags |
| aux_diag | output | DW | Aux value used by the last locked aux check |

## Verification
The assertions check several rules on every cycle. A refused start must set the error and leave the block idle. The stored fields must hold between writes. Each data-ready flag must rise on the same edge that busy falls. The aux diagnostic value may change only after a locked aux result taken during a run. The aux fault bits must stay still when no run or write is in progress. The threshold arithmetic at its edges, the result whose value equals the threshold, and the masking of disabled channels can only be shown by the bench's scenarios. The same goes for partial overwrites across runs, for duplicate or stray results during a run, and for go being dropped while busy.

// File: rtl/ow_diag_seq.sv
module ow_diag_seq #(
  parameter int DW       = 16,
  parameter int AW       = 4,
  parameter int THR_STEP = 256,
  parameter int THR_BASE = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [15:0]   vs_chan_en,
  input  logic          main_cont,
  input  logic          aux_cont,
  input  logic          aux_locked,
  input  logic          main_valid,
  input  logic [3:0]    main_chan,
  input  logic [DW-1:0] main_data,
  input  logic          aux_valid,
  input  logic [3:0]    aux_chan,
  input  logic [DW-1:0] aux_data,
  output logic [1:0]    sink_ctrl,
  output logic [2:0]    cmp_sel,
  output logic [3:0]    thr_code,
  output logic          busy,
  output logic          vs_drdy,
  output logic          aux_drdy,
  output logic          start_err,
  output logic [15:0]   vs_fault,
  output logic [15:0]   aux_fault,
  output logic [DW-1:0] aux_diag
);
  localparam int NCH = 16;
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_THR = AW'(1), A_STAT = AW'(2),
                            A_VSLO = AW'(3), A_VSHI = AW'(4),
                            A_AXLO = AW'(5), A_AXHI = AW'(6);
  localparam logic [2:0] SEL_VS = 3'b010, SEL_AUX = 3'b011;
  localparam int TW = DW + 8;

  logic           mode_aux;
  logic [NCH-1:0] seen, target, vs_q, hit;
  logic [TW-1:0]  thr;
  logic           wr_ctrl, go_vs, go_aux, start_ok, start_bad, vs_below, aux_below, vs_done;

  assign thr       = TW'(thr_code) * TW'(THR_STEP) + TW'(THR_BASE);
  assign vs_below  = TW'(main_data) < thr;
  assign aux_below = TW'(aux_data) < thr;

  assign wr_ctrl   = wr_en && wr_addr == A_CTRL;
  assign go_vs     = wr_ctrl && wr_data[3] && wr_data[2:0] == SEL_VS  && !busy;
  assign go_aux    = wr_ctrl && wr_data[3] && wr_data[2:0] == SEL_AUX && !busy;
  assign start_ok  = (go_vs && main_cont) || (go_aux && aux_cont);
  assign start_bad = (go_vs && !main_cont) || (go_aux && !aux_cont);

  assign hit      = (busy && !mode_aux && main_valid) ? (target & ~seen & (NCH'(1) << main_chan)) : '0;
  assign vs_done  = busy && !mode_aux && ((seen | hit) == target);
  assign vs_fault = vs_q & vs_chan_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sink_ctrl <= '0;  cmp_sel  <= '0;  thr_code  <= '0;
      busy      <= 1'b0; mode_aux <= 1'b0;
      seen      <= '0;  target   <= '0;
      vs_drdy   <= 1'b0; aux_drdy <= 1'b0; start_err <= 1'b0;
      vs_q      <= '0;  aux_fault <= '0; aux_diag  <= '0;
    end else begin
      if (wr_ctrl) begin
        cmp_sel   <= wr_data[2:0];
        sink_ctrl <= wr_data[5:4];
      end
      if (wr_en && wr_addr == A_THR) thr_code <= wr_data[3:0];
      if (wr_en && wr_addr == A_STAT) begin
        if (wr_data[0]) vs_drdy   <= 1'b0;
        if (wr_data[1]) aux_drdy  <= 1'b0;
        if (wr_data[2]) start_err <= 1'b0;
      end
      if (wr_en && wr_addr == A_VSLO) vs_q[7:0]       <= vs_q[7:0]       & ~wr_data;
      if (wr_en && wr_addr == A_VSHI) vs_q[15:8]      <= vs_q[15:8]      & ~wr_data;
      if (wr_en && wr_addr == A_AXLO) aux_fault[7:0]  <= aux_fault[7:0]  & ~wr_data;
      if (wr_en && wr_addr == A_AXHI) aux_fault[15:8] <= aux_fault[15:8] & ~wr_data;

      if (start_bad) start_err <= 1'b1;
      if (start_ok) begin
        busy     <= 1'b1;
        mode_aux <= go_aux;
        seen     <= '0;
        target   <= go_aux ? '0 : vs_chan_en;
        if (go_aux) aux_drdy <= 1'b0;
        else        vs_drdy  <= 1'b0;
      end

      for (int i = 0; i < NCH; i++)
        if (hit[i]) vs_q[i] <= vs_below;
      if (busy && !mode_aux) seen <= seen | hit;
      if (vs_done) begin
        busy    <= 1'b0;
        vs_drdy <= 1'b1;
      end

      if (busy && mode_aux && aux_valid) begin
        aux_fault[aux_chan] <= aux_below;
        if (aux_locked) aux_diag <= aux_data;
        busy     <= 1'b0;
        aux_drdy <= 1'b1;
      end
    end
  end
endmodule

module ow_diag_seq_chk #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          main_cont,
  input logic          aux_locked,
  input logic          aux_valid,
  input logic [1:0]    sink_ctrl,
  input logic [2:0]    cmp_sel,
  input logic [3:0]    thr_code,
  input logic          busy,
  input logic          vs_drdy,
  input logic          aux_drdy,
  input logic          start_err,
  input logic [15:0]   aux_fault,
  input logic [DW-1:0] aux_diag
);
  a_r8_refused_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0 && wr_data[3] && wr_data[2:0] == 3'b010 && !main_cont && !busy)
    |=> (start_err && !busy));

  a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(cmp_sel) && $stable(thr_code) && $stable(sink_ctrl)));

  a_r4_vs_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_drdy) |-> $fell(busy));

  a_r6_aux_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_drdy) |-> $fell(busy));

  a_r7_diag_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(aux_diag) |-> $past(busy && aux_valid && aux_locked));

  a_r5_idle_aux_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en) |=> $stable(aux_fault));
endmodule

bind ow_diag_seq ow_diag_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .main_cont(main_cont), .aux_locked(aux_locked), .aux_valid(aux_valid),
  .sink_ctrl(sink_ctrl), .cmp_sel(cmp_sel), .thr_code(thr_code), .busy(busy),
  .vs_drdy(vs_drdy), .aux_drdy(aux_drdy), .start_err(start_err),
  .aux_fault(aux_fault), .aux_diag(aux_diag)
);

// File: tb/ow_diag_seq_bench.sv
module ow_diag_seq_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] vs_chan_en = '0;
  logic        main_cont = 1'b0, aux_cont = 1'b0, aux_locked = 1'b0;
  logic        main_valid = 1'b0, aux_valid = 1'b0;
  logic [3:0]  main_chan = '0, aux_chan = '0;
  logic [15:0] main_data = '0, aux_data = '0;
  logic [1:0]  sink_ctrl;
  logic [2:0]  cmp_sel;
  logic [3:0]  thr_code;
  logic        busy, vs_drdy, aux_drdy, start_err;
  logic [15:0] vs_fault, aux_fault, aux_diag;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ow_diag_seq u_ow_diag_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vs_chan_en(vs_chan_en), .main_cont(main_cont), .aux_cont(aux_cont),
    .aux_locked(aux_locked), .main_valid(main_valid), .main_chan(main_chan),
    .main_data(main_data), .aux_valid(aux_valid), .aux_chan(aux_chan),
    .aux_data(aux_data), .sink_ctrl(sink_ctrl), .cmp_sel(cmp_sel),
    .thr_code(thr_code), .busy(busy), .vs_drdy(vs_drdy), .aux_drdy(aux_drdy),
    .start_err(start_err), .vs_fault(vs_fault), .aux_fault(aux_fault),
    .aux_diag(aux_diag)
  );

  // {chan[3:0], code[3:0], data[15:0], expected fault}; threshold = code*256+128
  localparam logic [24:0] TBL [0:7] = '{
    {4'd0,  4'd0,  16'd127,   1'b1},
    {4'd1,  4'd0,  16'd128,   1'b0},
    {4'd2,  4'd4,  16'd1151,  1'b1},
    {4'd3,  4'd4,  16'd1152,  1'b0},
    {4'd15, 4'd15, 16'd3967,  1'b1},
    {4'd8,  4'd15, 16'hFFFF,  1'b0},
    {4'd7,  4'd1,  16'd0,     1'b1},
    {4'd9,  4'd8,  16'd2000,  1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send_main(input logic [3:0] ch, input logic [15:0] d);
    @(negedge clk);
    main_valid = 1'b1; main_chan = ch; main_data = d;
    @(negedge clk);
    main_valid = 1'b0;
  endtask

  task automatic send_aux(input logic [3:0] ch, input logic [15:0] d);
    @(negedge clk);
    aux_valid = 1'b1; aux_chan = ch; aux_data = d;
    @(negedge clk);
    aux_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 flags", {vs_drdy, aux_drdy, start_err}, 0);
    check("R1 faults", {vs_fault, aux_fault}, 0);
    check("R1 fields", {aux_diag, cmp_sel, thr_code, sink_ctrl}, 0);

    wr(0, 8'h22);
    check("R2 sel", cmp_sel, 3'b010);
    check("R2 sink", sink_ctrl, 2'b10);
    check("R2 go not held", busy, 0);
    wr(1, 8'hF5);
    check("R2 thr", thr_code, 4'd5);

    main_cont = 1'b1;
    for (int i = 0; i < 8; i++) begin
      vs_chan_en = 16'd1 << TBL[i][24:21];
      wr(1, {4'd0, TBL[i][20:17]});
      wr(0, 8'h1A);
      send_main(TBL[i][24:21], TBL[i][16:1]);
      check("R3 table fault", vs_fault[TBL[i][24:21]], TBL[i][0]);
      check("R4 table done", {busy, vs_drdy}, 2'b01);
    end

    vs_chan_en = 16'h00F0;
    wr(1, 8'h02);
    wr(0, 8'h1A);
    check("R3 running", {busy, vs_drdy}, 2'b10);
    send_main(4'd4, 16'd100);
    send_main(4'd5, 16'd1000);
    send_main(4'd2, 16'd0);
    send_main(4'd4, 16'd5000);
    send_main(4'd6, 16'd639);
    check("R4 not done early", busy, 1);
    send_main(4'd7, 16'd640);
    check("R4 done on last", {busy, vs_drdy}, 2'b01);
    check("R3 multi faults", vs_fault, 16'h0050);

    vs_chan_en = 16'hFFFF;
    #1 check("R5 untouched kept", vs_fault, 16'h8255);
    vs_chan_en = 16'h0000;
    #1 check("R5 disabled zero", vs_fault, 16'h0000);
    vs_chan_en = 16'hFFFF;

    wr(3, 8'h05);
    check("R9 clear low", vs_fault, 16'h8250);
    wr(4, 8'h02);
    check("R9 clear high", vs_fault, 16'h8050);
    wr(2, 8'h01);
    check("R9 clear drdy", vs_drdy, 0);

    main_cont = 1'b0;
    wr(0, 8'h1A);
    check("R8 no run", busy, 0);
    check("R8 err set", start_err, 1);
    check("R8 faults kept", vs_fault, 16'h8050);
    wr(2, 8'h04);
    check("R9 clear err", start_err, 0);
    main_cont = 1'b1;

    wr(0, 8'h19);
    check("R10 bad sel", {busy, start_err}, 2'b00);

    vs_chan_en = 16'h0001;
    wr(0, 8'h1A);
    aux_cont = 1'b1;
    wr(0, 8'h1B);
    send_aux(4'd3, 16'd0);
    check("R10 go while busy ignored", busy, 1);
    check("R10 aux untouched", {aux_drdy, aux_fault}, 0);
    send_main(4'd0, 16'd60000);
    check("R4 single done", {busy, vs_drdy}, 2'b01);

    vs_chan_en = 16'h0000;
    wr(0, 8'h1A);
    check("R4 empty start", {busy, vs_drdy}, 2'b10);
    @(negedge clk);
    check("R4 empty done", {busy, vs_drdy}, 2'b01);

    aux_locked = 1'b1;
    wr(1, 8'h03);
    wr(0, 8'h1B);
    check("R6 aux running", busy, 1);
    send_aux(4'd5, 16'd800);
    check("R6 aux fault", aux_fault, 16'h0020);
    check("R6 aux drdy", {busy, aux_drdy}, 2'b01);
    check("R7 diag copy", aux_diag, 16'd800);

    aux_locked = 1'b0;
    wr(0, 8'h1B);
    send_aux(4'd5, 16'd2000);
    check("R6 aux overwrite", aux_fault, 16'h0000);
    check("R7 unlocked no copy", aux_diag, 16'd800);
    wr(2, 8'h02);
    check("R9 clear aux drdy", aux_drdy, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule